// File: doc/BRIEF.md
# Register-Driven CRC-16 Engine

This block computes the 16-bit CCITT checksum for asynchronous infrared frames, one byte per bus write. Software, or a datapath master, clears the engine through a control bit, writes bytes to a data register, and reads back both the number of bytes taken since the clear and the checksum so far. Frame assembly and automatic checksum insertion are left to the block's users.

The engine uses the reflected polynomial 0x8408 with a preset of 0xFFFF, and takes each byte least significant bit first. The result register shows the bitwise inverse of the running remainder. Every data write is folded in within a single cycle, so the new result and count can be read on the next cycle. A fixed known-answer sequence lets software test the engine after power-up.

Top module: `irlink_crc16`

## Requirements
- R1: A write to the control register (word address 0) with bit 15 set makes the remainder 0xFFFF and the input count 0 from the next cycle. The result register then reads 0x0000.
- R2: A write to the control register with bit 15 clear changes neither the count nor the result.
- R3: A write to the data register (word address 1) folds bits 7:0 of the write into the remainder, using the reflected polynomial 0x8408 with the least significant bit first. Bits 15:8 of the write have no effect on the result.
- R4: The result register (word address 2) reads the bitwise inverse of the remainder. It shows the effect of a data write on the cycle after that write.
- R5: Each data write adds one to the input count, which reads in control bits 11:0. Control bits 15:12 always read 0.
- R6: The input count saturates at 0xFFF. Data writes made at saturation still update the result.
- R7: After reset the count reads 0 and the result reads 0x0000.
- R8: After a clear, writing the bytes 0xCC, 0xF5, 0xF1 and 0xA7 in that order gives a count of 4 and a result of 0x51DF.
- R9: Reads are combinational from registered state. In the cycle of a write, the read data shows the addressed register's contents from before that write.
- R10: Word address 3 reads 0, and writes to it or to the result register change nothing. The data register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word address of the register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |

## Verification
The byte fold and the saturating count both act on the same data write. The risky case is once the counter reaches 0xFFF: there it must hold while the remainder keeps changing. The bench drives more than 4096 writes of varying bytes after a clear. It then compares the count with 0xFFF and the result with a bit-serial model that has seen every byte. A second case is a clear issued while the control register is being read: the old count must appear in that same cycle and zero in the next.

// File: rtl/irlink_crc16_pkg.sv
package irlink_crc16_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 12;
  localparam int CLR_BIT = 15;

  localparam logic [ADDR_W-1:0] RA_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] RA_DIN    = 2'd1;
  localparam logic [ADDR_W-1:0] RA_RESULT = 2'd2;

  // Fold one byte into a reflected remainder, LSB first.
  function automatic logic [REG_W-1:0] crc_fold_byte(
    input logic [REG_W-1:0]  cur,
    input logic [BYTE_W-1:0] data,
    input logic [REG_W-1:0]  poly
  );
    logic [REG_W-1:0] r;
    r = cur ^ {{(REG_W-BYTE_W){1'b0}}, data};
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0]) r = (r >> 1) ^ poly;
      else      r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/irlink_crc16_decode.sv
module irlink_crc16_decode
  import irlink_crc16_pkg::*;
(
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [REG_W-1:0]  crc_result,
  output logic              clr_pulse,
  output logic              din_pulse,
  output logic [BYTE_W-1:0] din_byte,
  output logic [REG_W-1:0]  bus_rdata
);
  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[REG_W-1:CLR_BIT+1], bus_wdata[CLR_BIT-1:BYTE_W]};

  assign clr_pulse = bus_we && (bus_addr == RA_CTRL) && bus_wdata[CLR_BIT];
  assign din_pulse = bus_we && (bus_addr == RA_DIN);
  assign din_byte  = bus_wdata[BYTE_W-1:0];

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      RA_CTRL:   bus_rdata = {{(REG_W-CNT_W){1'b0}}, in_count};
      RA_RESULT: bus_rdata = crc_result;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irlink_crc16_core.sv
module irlink_crc16_core
  import irlink_crc16_pkg::*;
#(
  parameter logic [REG_W-1:0] POLY   = 16'h8408,
  parameter logic [REG_W-1:0] PRESET = 16'hFFFF,
  parameter logic [REG_W-1:0] XOROUT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [BYTE_W-1:0] data,
  output logic [REG_W-1:0]  state,
  output logic [REG_W-1:0]  result
);
  logic [REG_W-1:0] next_state;

  always_comb begin
    next_state = state;
    if (clr)       next_state = PRESET;
    else if (load) next_state = crc_fold_byte(state, data, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PRESET;
    else        state <= next_state;
  end

  assign result = state ^ XOROUT;
endmodule

// File: rtl/irlink_crc16_counter.sv
module irlink_crc16_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assign full = (count == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count <= '0;
    else if (clr)         count <= '0;
    else if (inc && !full) count <= count + 1'b1;
  end
endmodule

// File: rtl/irlink_crc16.sv
module irlink_crc16
  import irlink_crc16_pkg::*;
#(
  parameter logic [REG_W-1:0] POLY   = 16'h8408,
  parameter logic [REG_W-1:0] PRESET = 16'hFFFF,
  parameter logic [REG_W-1:0] XOROUT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata
);
  logic              clr_pulse;
  logic              din_pulse;
  logic [BYTE_W-1:0] din_byte;
  logic [REG_W-1:0]  crc_state;
  logic [REG_W-1:0]  crc_result;
  logic [CNT_W-1:0]  in_count;
  logic              cnt_full;

  irlink_crc16_decode u_decode (
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .in_count   (in_count),
    .crc_result (crc_result),
    .clr_pulse  (clr_pulse),
    .din_pulse  (din_pulse),
    .din_byte   (din_byte),
    .bus_rdata  (bus_rdata)
  );

  irlink_crc16_core #(
    .POLY   (POLY),
    .PRESET (PRESET),
    .XOROUT (XOROUT)
  ) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_pulse),
    .load   (din_pulse),
    .data   (din_byte),
    .state  (crc_state),
    .result (crc_result)
  );

  irlink_crc16_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_pulse),
    .inc   (din_pulse),
    .count (in_count),
    .full  (cnt_full)
  );
endmodule

// File: rtl/irlink_crc16_chk.sv
module irlink_crc16_chk
  import irlink_crc16_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              clr_pulse,
  input logic              din_pulse,
  input logic [REG_W-1:0]  crc_state,
  input logic [CNT_W-1:0]  in_count,
  input logic              cnt_full
);
  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (crc_state == 16'hFFFF) && (in_count == '0));

  a_r2_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_pulse && !din_pulse) |=> $stable(crc_state) && $stable(in_count));

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (din_pulse && !clr_pulse && !cnt_full) |=> (in_count == $past(in_count) + 1'b1));

  a_r5_ctrl_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == RA_CTRL) |-> (bus_rdata[REG_W-1:CNT_W] == '0));

  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (din_pulse && !clr_pulse && cnt_full) |=> cnt_full);

  a_r10_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3 || bus_addr == RA_DIN) |-> (bus_rdata == '0));
endmodule

bind irlink_crc16 irlink_crc16_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .clr_pulse (clr_pulse),
  .din_pulse (din_pulse),
  .crc_state (crc_state),
  .in_count  (in_count),
  .cnt_full  (cnt_full)
);

// File: tb/irlink_crc16_bench.sv
module irlink_crc16_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  irlink_crc16 u_irlink_crc16 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Data words: upper bytes carry junk that must be ignored (R3).
  localparam logic [15:0] VEC [8] = '{
    16'h0031, 16'hA532, 16'hFF33, 16'h0034,
    16'h1235, 16'h8036, 16'h7F00, 16'hC3FF
  };

  // Bit-serial model: feedback bit is remainder LSB xor data bit.
  function automatic logic [15:0] model_step(input logic [15:0] cur, input logic [7:0] b);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb  = cur[0] ^ b[i];
      cur = {1'b0, cur[15:1]};
      if (fb) cur = cur ^ 16'h8408;
    end
    return cur;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic void summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    rd(2'd0, v); check("R7 count after reset", v, 16'h0000);
    rd(2'd2, v); check("R7 result after reset", v, 16'h0000);

    // Table walk: running model, R3/R4/R5
    m = 16'hFFFF;
    foreach (VEC[k]) begin
      wr(2'd1, VEC[k]);
      m = model_step(m, VEC[k][7:0]);
      rd(2'd2, v); check("R3 R4 result after byte", v, ~m);
      rd(2'd0, v); check("R5 count after byte", v, 16'(k + 1));
    end

    // R2 ctrl write without clear bit
    wr(2'd0, 16'h7FFF);
    rd(2'd0, v); check("R2 count kept", v, 16'd8);
    rd(2'd2, v); check("R2 result kept", v, ~m);

    // R10 spare and result writes ignored, reads zero
    wr(2'd3, 16'hFFFF);
    wr(2'd2, 16'h1234);
    rd(2'd2, v); check("R10 result kept", v, ~m);
    rd(2'd3, v); check("R10 spare reads 0", v, 16'h0000);
    rd(2'd1, v); check("R10 data reads 0", v, 16'h0000);

    // R9 clear while reading ctrl: old count in same cycle
    @(negedge clk);
    bus_addr = 2'd0; bus_we = 1'b1; bus_wdata = 16'h8000;
    #1 check("R9 old count during clear", bus_rdata, 16'd8);
    @(negedge clk);
    bus_we = 1'b0;
    #1 check("R1 count zero after clear", bus_rdata, 16'h0000);
    rd(2'd2, v); check("R1 result after clear", v, 16'h0000);

    // R8 known-answer vector
    wr(2'd1, 16'h00CC); wr(2'd1, 16'h00F5); wr(2'd1, 16'h00F1); wr(2'd1, 16'h00A7);
    rd(2'd0, v); check("R8 count", v, 16'd4);
    rd(2'd2, v); check("R8 result", v, 16'h51DF);

    // R6 saturation while the remainder keeps folding
    wr(2'd0, 16'h8000);
    m = 16'hFFFF;
    for (int i = 0; i < 4100; i++) begin
      wr(2'd1, 16'(i * 7 + 3));
      m = model_step(m, 8'(i * 7 + 3));
    end
    rd(2'd0, v); check("R6 count saturated", v, 16'h0FFF);
    rd(2'd2, v); check("R6 result past saturation", v, ~m);
    wr(2'd1, 16'h005A);
    m = model_step(m, 8'h5A);
    rd(2'd0, v); check("R6 count held", v, 16'h0FFF);
    rd(2'd2, v); check("R6 result still folds", v, ~m);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule